// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible registers of one DMA channel. A register bus reaches sixteen 32-bit slots, each four bytes apart, using either 16-bit or 32-bit accesses. The block drives the programmed values to the address generator and the descriptor engine. It takes back their status events and their current-position values.

The channel is started and stopped by writing the config register. While the channel runs, most registers are locked against software writes. The interrupt status register reports completion and error. Its completion and error bits are write-one-to-clear, and its run flag is read-only. The channel-type bit of the peripheral map is fixed after reset. A bus access with an illegal size or alignment raises the bus error, and so does a write to a reserved slot.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads zero except the peripheral map, which holds the DEF_MAP parameter. RUN, start_o and stop_o are low.
- R2: bus_size 2'b01 is a 16-bit access and needs bus_addr[0]=0. bus_size 2'b10 is a 32-bit access and needs bus_addr[1:0]=0. Any other size or alignment raises bus_err in the same cycle, returns read data zero and changes nothing. This check comes before the reserved-slot check.
- R3: The slot is bus_addr[5:2], in this order:
  - 0: next-descriptor pointer
  - 1: start address
  - 2: config
  - 4: X count
  - 5: X modify
  - 6: Y count
  - 7: Y modify
  - 8: current-descriptor pointer
  - 9: current address
  - 10: interrupt status
  - 11: peripheral map
  - 12: current X count
  - 14: current Y count
  - 3, 13 and 15: reserved

  A 32-bit read returns the whole slot. A 16-bit read returns the half that bus_addr[1] selects, in rdata[15:0], with the upper bits zero. 16-bit registers sit in bits 15:0 of their slot. Reserved slots read zero and raise no error.
- R4: While RUN (status bit 3) is set, writes to slots 0, 1, 4 to 9, 11, 12 and 14 are discarded without error.
- R5: A write to config (slot 2, either 32-bit or 16-bit with bus_addr[1]=0) is always stored.
  - If bit 0 is 1, RUN is set at the next edge and start_o pulses for one cycle.
  - If bit 0 is 0, RUN is cleared and stop_o pulses for one cycle.
- R6: In the interrupt status register, writing 1 to bit 0 (DONE) or to bit 1 (ERR) clears that bit. Bus writes never change RUN (bit 3).
- R7: A write to the peripheral map updates every bit except bit CT_BIT (the channel type, default 6), which keeps its value.
- R8: A legal-size write to a reserved slot raises bus_err and changes nothing.
- R9: 16-bit data rides in bus_wdata[15:0].
  - A 16-bit write to a 32-bit slot (0, 1, 8, 9) updates only the half that bus_addr[1] selects.
  - A 32-bit write to a 16-bit register stores bus_wdata[15:0].
  - A 16-bit write with bus_addr[1]=1 to a 16-bit register, config included, has no effect and raises no error.
- R10: eng_done sets DONE and clears RUN. eng_err sets ERR.
  - A set event wins over a write-one-to-clear in the same cycle.
  - A config write decides RUN over eng_done in the same cycle.
- R11: eng_ld loads the current-descriptor pointer, current address, current X count and current Y count from the engine inputs, and wins over a bus write in the same cycle.
- R12: The outputs next_desc_o, start_addr_o, config_o, x_count_o, x_mod_o, y_count_o, y_mod_o and pmap_o always show the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 01 = 16-bit, 10 = 32-bit, others illegal |
| bus_addr | input | 6 | Byte offset within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Access error (combinational) |
| eng_ld | input | 1 | Load current-position registers |
| eng_desc | input | 32 | Current descriptor pointer from engine |
| eng_addr | input | 32 | Current address from engine |
| eng_xcnt | input | 16 | Current X count from engine |
| eng_ycnt | input | 16 | Current Y count from engine |
| eng_done | input | 1 | Transfer complete event |
| eng_err | input | 1 | Transfer error event |
| start_o | output | 1 | One-cycle start request to the descriptor engine |
| stop_o | output | 1 | One-cycle cancel request |
| running_o | output | 1 | RUN flag |
| next_desc_o | output | 32 | Next-descriptor pointer |
| start_addr_o | output | 32 | Start address |
| config_o | output | 16 | Config register |
| x_count_o | output | 16 | X count |
| x_mod_o | output | 16 | X modify |
| y_count_o | output | 16 | Y count |
| y_mod_o | output | 16 | Y modify |
| pmap_o | output | 16 | Peripheral map |

## Verification
The assertions check on every cycle that:
- an illegal size or a reserved-slot write raises the error;
- a locked X count stays put while the channel runs;
- a start write raises RUN together with start_o;
- a DONE clear takes effect;
- the channel-type bit never moves;
- eng_done drops RUN.

Only the bench's scenarios can show the following:
- the exact read data for each slot and half;
- the half-word merging into pointers;
- the set-versus-clear and load-versus-write priorities;
- that discarded writes leave every register untouched.

The bench compares all of these against a shadow model under random access mixes.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DW    = 32;
  localparam int HW    = 16;
  localparam int SLOTS = 16;
  localparam int AW    = $clog2(SLOTS) + 2;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RUN  = 3;
  localparam int CFG_EN  = 0;

  localparam logic [3:0] S_NDP   = 4'd0;
  localparam logic [3:0] S_SADDR = 4'd1;
  localparam logic [3:0] S_CFG   = 4'd2;
  localparam logic [3:0] S_XCNT  = 4'd4;
  localparam logic [3:0] S_CDP   = 4'd8;
  localparam logic [3:0] S_CADDR = 4'd9;
  localparam logic [3:0] S_STAT  = 4'd10;
  localparam logic [3:0] S_PMAP  = 4'd11;
  localparam logic [3:0] S_CXCNT = 4'd12;
  localparam logic [3:0] S_CYCNT = 4'd14;

  function automatic logic is_reserved(input logic [3:0] s);
    return (s == 4'd3) || (s == 4'd13) || (s == 4'd15);
  endfunction

  // slot of the k-th 32-bit pointer: 0, 1, 8, 9
  function automatic logic [3:0] ptr_slot(input int k);
    return {k[1], 2'b00, k[0]};
  endfunction

  function automatic logic [DW-1:0] put_half(input logic [DW-1:0] old,
                                             input logic hi,
                                             input logic [HW-1:0] v);
    return hi ? {v, old[HW-1:0]} : {old[DW-1:HW], v};
  endfunction

  function automatic logic [HW-1:0] keep_bit(input logic [HW-1:0] old,
                                             input logic [HW-1:0] nw,
                                             input int pos);
    logic [HW-1:0] m;
    m = HW'(1) << pos;
    return (old & m) | (nw & ~m);
  endfunction
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode import dcr_pkg::*; (
  input  logic          sel,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  output logic [3:0]    slot,
  output logic          legal,
  output logic          wide,
  output logic          hi,
  output logic          wr_any,
  output logic          wr_lo,
  output logic          err
);
  logic rsv;

  always_comb begin
    slot   = addr[AW-1:2];
    wide   = (size == SZ_WORD);
    legal  = ((size == SZ_HALF) && !addr[0]) ||
             ((size == SZ_WORD) && (addr[1:0] == 2'b00));
    hi     = !wide && addr[1];
    rsv    = is_reserved(slot);
    err    = sel && (!legal || (we && rsv));
    wr_any = sel && we && legal && !rsv;
    wr_lo  = wr_any && !hi;
  end
endmodule

// File: rtl/dcr_status.sv
module dcr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       stat_wr,
  input  logic [1:0] stat_clr,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic       run_q,
  output logic       done_q,
  output logic       err_q,
  output logic       start_p,
  output logic       stop_p
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
    end else begin
      if (cfg_wr)        run_q <= cfg_en;
      else if (eng_done) run_q <= 1'b0;
      if (eng_done)                     done_q <= 1'b1;
      else if (stat_wr && stat_clr[0])  done_q <= 1'b0;
      if (eng_err)                      err_q  <= 1'b1;
      else if (stat_wr && stat_clr[1])  err_q  <= 1'b0;
      start_p <= cfg_wr && cfg_en;
      stop_p  <= cfg_wr && !cfg_en;
    end
  end
endmodule

// File: rtl/dcr_readmux.sv
module dcr_readmux import dcr_pkg::*; (
  input  logic [SLOTS-1:0][DW-1:0] words,
  input  logic [3:0]               slot,
  input  logic                     legal,
  input  logic                     wide,
  input  logic                     hi,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] w;

  always_comb begin
    w = words[slot];
    if (!legal)     rdata = '0;
    else if (wide)  rdata = w;
    else if (hi)    rdata = {{(DW-HW){1'b0}}, w[DW-1:HW]};
    else            rdata = {{(DW-HW){1'b0}}, w[HW-1:0]};
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dcr_pkg::*; #(
  parameter logic [HW-1:0] DEF_MAP = 16'h0043,
  parameter int            CT_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  input  logic          eng_ld,
  input  logic [DW-1:0] eng_desc,
  input  logic [DW-1:0] eng_addr,
  input  logic [HW-1:0] eng_xcnt,
  input  logic [HW-1:0] eng_ycnt,
  input  logic          eng_done,
  input  logic          eng_err,
  output logic          start_o,
  output logic          stop_o,
  output logic          running_o,
  output logic [DW-1:0] next_desc_o,
  output logic [DW-1:0] start_addr_o,
  output logic [HW-1:0] config_o,
  output logic [HW-1:0] x_count_o,
  output logic [HW-1:0] x_mod_o,
  output logic [HW-1:0] y_count_o,
  output logic [HW-1:0] y_mod_o,
  output logic [HW-1:0] pmap_o
);
  localparam int NPTR = 4;
  localparam int NSH  = 4;

  logic [3:0] slot;
  logic       legal, wide, hi, wr_any, wr_lo;
  logic       run_q, stat_done, stat_err;
  logic       cfg_wr, stat_wr, wr_open;

  // named events for the checker
  logic       cfg_start_evt;

  dcr_decode u_dec (
    .sel(bus_sel), .we(bus_we), .size(bus_size), .addr(bus_addr),
    .slot(slot), .legal(legal), .wide(wide), .hi(hi),
    .wr_any(wr_any), .wr_lo(wr_lo), .err(bus_err)
  );

  assign wr_open       = wr_any && !run_q;
  assign cfg_wr        = wr_lo && (slot == S_CFG);
  assign stat_wr       = wr_lo && (slot == S_STAT);
  assign cfg_start_evt = cfg_wr && bus_wdata[CFG_EN];

  dcr_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_en(bus_wdata[CFG_EN]),
    .stat_wr(stat_wr), .stat_clr({bus_wdata[ST_ERR], bus_wdata[ST_DONE]}),
    .eng_done(eng_done), .eng_err(eng_err),
    .run_q(run_q), .done_q(stat_done), .err_q(stat_err),
    .start_p(start_o), .stop_p(stop_o)
  );

  // 32-bit pointers: slots 0, 1, 8, 9; the last two are engine-loaded
  logic [DW-1:0] ptr_q   [NPTR];
  logic [DW-1:0] ptr_eng [NPTR];
  assign ptr_eng[0] = '0;
  assign ptr_eng[1] = '0;
  assign ptr_eng[2] = eng_desc;
  assign ptr_eng[3] = eng_addr;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    localparam logic [3:0] PS     = ptr_slot(gi);
    localparam bit         ENG_LD = (gi >= 2);
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[gi] <= '0;
      else if (ENG_LD && eng_ld)
        ptr_q[gi] <= ptr_eng[gi];
      else if (wr_open && slot == PS)
        ptr_q[gi] <= wide ? bus_wdata : put_half(ptr_q[gi], hi, bus_wdata[HW-1:0]);
    end
  end

  // 16-bit shape registers: slots 4..7
  logic [HW-1:0] sh_q [NSH];
  for (genvar gi = 0; gi < NSH; gi++) begin : g_shape
    localparam logic [3:0] SS = S_XCNT + 4'(gi);
    always_ff @(posedge clk) begin
      if (!rst_n)                          sh_q[gi] <= '0;
      else if (wr_open && !hi && slot == SS) sh_q[gi] <= bus_wdata[HW-1:0];
    end
  end

  logic [HW-1:0] cfg_q, pmap_q, cx_q, cy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pmap_q <= DEF_MAP;
      cx_q   <= '0;
      cy_q   <= '0;
    end else begin
      if (cfg_wr) cfg_q <= bus_wdata[HW-1:0];
      if (wr_open && !hi && slot == S_PMAP)
        pmap_q <= keep_bit(pmap_q, bus_wdata[HW-1:0], CT_BIT);
      if (eng_ld)                                 cx_q <= eng_xcnt;
      else if (wr_open && !hi && slot == S_CXCNT) cx_q <= bus_wdata[HW-1:0];
      if (eng_ld)                                 cy_q <= eng_ycnt;
      else if (wr_open && !hi && slot == S_CYCNT) cy_q <= bus_wdata[HW-1:0];
    end
  end

  logic [SLOTS-1:0][DW-1:0] words;
  always_comb begin
    words = '0;
    for (int k = 0; k < NPTR; k++) words[ptr_slot(k)] = ptr_q[k];
    for (int k = 0; k < NSH; k++)  words[S_XCNT + 4'(k)] = {{(DW-HW){1'b0}}, sh_q[k]};
    words[S_CFG]   = {{(DW-HW){1'b0}}, cfg_q};
    words[S_PMAP]  = {{(DW-HW){1'b0}}, pmap_q};
    words[S_CXCNT] = {{(DW-HW){1'b0}}, cx_q};
    words[S_CYCNT] = {{(DW-HW){1'b0}}, cy_q};
    words[S_STAT][ST_DONE] = stat_done;
    words[S_STAT][ST_ERR]  = stat_err;
    words[S_STAT][ST_RUN]  = run_q;
  end

  dcr_readmux u_rd (
    .words(words), .slot(slot), .legal(legal), .wide(wide), .hi(hi),
    .rdata(bus_rdata)
  );

  assign running_o    = run_q;
  assign next_desc_o  = ptr_q[0];
  assign start_addr_o = ptr_q[1];
  assign config_o     = cfg_q;
  assign x_count_o    = sh_q[0];
  assign x_mod_o      = sh_q[1];
  assign y_count_o    = sh_q[2];
  assign y_mod_o      = sh_q[3];
  assign pmap_o       = pmap_q;
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk import dcr_pkg::*; #(
  parameter int CT_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_size,
  input logic [AW-1:0] bus_addr,
  input logic          bus_err,
  input logic          eng_done,
  input logic          running_o,
  input logic          start_o,
  input logic [HW-1:0] x_count_o,
  input logic [HW-1:0] pmap_o,
  input logic          cfg_wr,
  input logic          cfg_start_evt,
  input logic          stat_wr,
  input logic [1:0]    clr_bits,
  input logic          stat_done
);
  logic ok_access;
  assign ok_access = ((bus_size == SZ_HALF) && !bus_addr[0]) ||
                     ((bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00));

  // R2
  a_r2_bad_access_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !ok_access) |-> bus_err);

  // R8
  a_r8_rsv_wr_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && ok_access &&
     (bus_addr[AW-1:2] == 4'd3 || bus_addr[AW-1:2] == 4'd13 || bus_addr[AW-1:2] == 4'd15))
    |-> bus_err);

  // R4
  a_r4_xcnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && running_o && bus_addr[AW-1:2] == S_XCNT) |=> $stable(x_count_o));

  // R5
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start_evt |=> (start_o && running_o));

  a_r5_run_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> start_o);

  // R6
  a_r6_done_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && clr_bits[0] && !eng_done) |=> !stat_done);

  // R7
  a_r7_ctype_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pmap_o[CT_BIT]));

  // R10
  a_r10_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_wr) |=> !running_o);
endmodule

bind dma_chan_regs dcr_chk #(.CT_BIT(CT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_err(bus_err),
  .eng_done(eng_done), .running_o(running_o), .start_o(start_o),
  .x_count_o(x_count_o), .pmap_o(pmap_o), .cfg_wr(cfg_wr),
  .cfg_start_evt(cfg_start_evt), .stat_wr(stat_wr),
  .clr_bits({bus_wdata[1], bus_wdata[0]}), .stat_done(stat_done)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] DEF_MAP    = 16'h0043;
  localparam int          CT         = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_size = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        bus_err;
  logic        eng_ld = 0, eng_done = 0, eng_err = 0;
  logic [31:0] eng_desc = 0, eng_addr = 0;
  logic [15:0] eng_xcnt = 0, eng_ycnt = 0;
  logic        start_o, stop_o, running_o;
  logic [31:0] next_desc_o, start_addr_o;
  logic [15:0] config_o, x_count_o, x_mod_o, y_count_o, y_mod_o, pmap_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.DEF_MAP(DEF_MAP), .CT_BIT(CT)) u0 (.*);

  int checks = 0, fails = 0;
  logic [31:0] m [16];
  logic m_run = 0, m_done = 0, m_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit rsv(input logic [3:0] s);
    return s == 3 || s == 13 || s == 15;
  endfunction

  function automatic bit wide_reg(input logic [3:0] s);
    return s == 0 || s == 1 || s == 8 || s == 9;
  endfunction

  function automatic logic [31:0] m_word(input logic [3:0] s);
    if (s == 10) return {28'h0, m_run, 1'b0, m_err, m_done};
    return m[s];
  endfunction

  function automatic bit good(input logic [1:0] sz, input logic [5:0] a);
    return (sz == 2'b01 && !a[0]) || (sz == 2'b10 && a[1:0] == 2'b00);
  endfunction

  function automatic bit exp_err(input logic we, input logic [1:0] sz, input logic [5:0] a);
    if (!good(sz, a)) return 1'b1;
    return we && rsv(a[5:2]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [5:0] a);
    logic [31:0] w;
    w = m_word(a[5:2]);
    if (!good(sz, a)) return 32'h0;
    if (sz == 2'b10) return w;
    return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  task automatic model_wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
    logic [3:0] s;
    logic [15:0] v;
    s = a[5:2];
    v = d[15:0];
    if (exp_err(1'b1, sz, a)) return;
    if (wide_reg(s)) begin
      if (!m_run) begin
        if (sz == 2'b10)  m[s] = d;
        else if (a[1])   m[s][31:16] = v;
        else             m[s][15:0] = v;
      end
      return;
    end
    if (sz == 2'b01 && a[1]) return;
    case (s)
      4'd2:  begin m[2] = {16'h0, v}; m_run = v[0]; end
      4'd10: begin if (v[0]) m_done = 0; if (v[1]) m_err = 0; end
      4'd11: if (!m_run) m[11] = {16'h0, (v & ~16'h0040) | (m[11][15:0] & 16'h0040)};
      default: if (!m_run) m[s] = {16'h0, v};
    endcase
  endtask

  task automatic bus(input logic we, input logic [1:0] sz, input logic [5:0] a,
                     input logic [31:0] d, output logic e, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
    #1;
    e = bus_err; rd = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic op(input logic we, input logic [1:0] sz, input logic [5:0] a,
                    input logic [31:0] d, input string tag);
    logic e, xe;
    logic [31:0] rd, xr;
    xe = exp_err(we, sz, a);
    xr = exp_rd(sz, a);
    bus(we, sz, a, d, e, rd);
    chk(e == xe, {tag, " bus_err"}, 32'(e), 32'(xe));
    if (!we) chk(rd == xr, {tag, " rdata"}, rd, xr);
    if (we) model_wr(sz, a, d);
    chk(running_o == m_run, {tag, " running"}, 32'(running_o), 32'(m_run));
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic e;
    logic [31:0] rd;
    bus(1'b0, 2'b10, a, 32'h0, e, rd);
    chk(rd == exp && !e, tag, rd, exp);
  endtask

  task automatic eng_pulse(input logic dn, input logic er);
    @(negedge clk);
    eng_done = dn; eng_err = er;
    @(posedge clk); #1;
    eng_done = 0; eng_err = 0;
    if (dn) begin m_run = 0; m_done = 1; end
    if (er) m_err = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic e;
    logic [31:0] rd;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    m[11] = {16'h0, DEF_MAP};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;

    // R1 reset state
    chk(pmap_o == DEF_MAP, "R1 pmap_o reset", 32'(pmap_o), 32'(DEF_MAP));
    chk(!running_o && !start_o && !stop_o, "R1 control reset", {29'h0, running_o, start_o, stop_o}, 0);
    chk(config_o == 0 && x_count_o == 0 && next_desc_o == 0, "R1 regs reset", 32'(config_o), 0);
    for (int s = 0; s < 16; s++) op(1'b0, 2'b10, 6'(s * 4), 0, "R1 R3 reset read");

    // R2 illegal size/alignment
    op(1'b1, 2'b00, 6'h10, 32'h5, "R2 byte write");
    op(1'b0, 2'b11, 6'h10, 32'h0, "R2 bad size read");
    op(1'b1, 2'b01, 6'h11, 32'h9, "R2 odd address");
    op(1'b1, 2'b10, 6'h12, 32'h9, "R2 misaligned word");
    op(1'b1, 2'b00, 6'h0C, 32'h9, "R2 size before reserved");
    expect_rd(6'h10, 32'h0, "R2 no effect");

    // R9 half writes
    op(1'b1, 2'b01, 6'h02, 32'h0000_BEEF, "R9 ptr high half");
    expect_rd(6'h00, 32'hBEEF_0000, "R9 ptr high half value");
    op(1'b1, 2'b01, 6'h00, 32'h0000_1234, "R9 ptr low half");
    expect_rd(6'h00, 32'hBEEF_1234, "R9 ptr both halves");
    op(1'b1, 2'b10, 6'h10, 32'hAAAA_5555, "R9 word to 16-bit reg");
    expect_rd(6'h10, 32'h0000_5555, "R9 low half kept");
    op(1'b1, 2'b01, 6'h12, 32'h0000_7777, "R9 upper half of 16-bit reg");
    chk(x_count_o == 16'h5555, "R12 x_count_o", 32'(x_count_o), 32'h5555);
    op(1'b0, 2'b01, 6'h02, 0, "R3 half read high");

    // R7 channel-type bit
    op(1'b1, 2'b10, 6'h2C, 32'h0, "R7 pmap zero");
    expect_rd(6'h2C, 32'h0000_0040, "R7 ctype kept set");
    op(1'b1, 2'b01, 6'h2C, 32'h0000_FFBF, "R7 pmap ones");
    chk(pmap_o == 16'hFFFF, "R7 pmap_o", 32'(pmap_o), 32'hFFFF);

    // R8 reserved slots
    op(1'b1, 2'b10, 6'h0C, 32'h1, "R8 reserved write");
    op(1'b1, 2'b01, 6'h34, 32'h1, "R8 reserved 13");
    op(1'b0, 2'b10, 6'h3C, 0, "R3 reserved read");

    // R5 start
    op(1'b1, 2'b10, 6'h08, 32'h0000_0005, "R5 config start");
    chk(start_o && running_o, "R5 start_o pulse", {30'h0, start_o, running_o}, 3);
    chk(config_o == 16'h5, "R12 config_o", 32'(config_o), 5);
    @(posedge clk); #1;
    chk(!start_o, "R5 start_o one cycle", 32'(start_o), 0);
    expect_rd(6'h28, 32'h0000_0008, "R3 R6 status run");

    // R4 writes discarded while running
    op(1'b1, 2'b10, 6'h10, 32'h1111, "R4 xcount locked");
    op(1'b1, 2'b10, 6'h00, 32'h0, "R4 ptr locked");
    op(1'b1, 2'b10, 6'h2C, 32'h0, "R4 pmap locked");
    expect_rd(6'h00, 32'hBEEF_1234, "R4 ptr value");
    chk(x_count_o == 16'h5555, "R4 x_count_o", 32'(x_count_o), 32'h5555);
    op(1'b1, 2'b10, 6'h28, 32'hF, "R6 run not writable");
    expect_rd(6'h28, 32'h8, "R6 run kept");

    // R10 engine events
    eng_pulse(1'b1, 1'b0);
    chk(!running_o, "R10 done stops", 32'(running_o), 0);
    expect_rd(6'h28, 32'h1, "R10 done set");
    eng_pulse(1'b0, 1'b1);
    expect_rd(6'h28, 32'h3, "R10 err set");
    op(1'b1, 2'b01, 6'h28, 32'h1, "R6 clear done");
    expect_rd(6'h28, 32'h2, "R6 err left");
    op(1'b1, 2'b10, 6'h28, 32'h2, "R6 clear err");
    expect_rd(6'h28, 32'h0, "R6 all clear");
    // set beats clear in the same cycle
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_size = 2'b10; bus_addr = 6'h28; bus_wdata = 32'h3;
    eng_done = 1; eng_err = 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; eng_done = 0; eng_err = 0;
    m_done = 1; m_err = 1; m_run = 0;
    expect_rd(6'h28, 32'h3, "R10 set wins over clear");
    // config write beats eng_done for RUN
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_size = 2'b10; bus_addr = 6'h08; bus_wdata = 32'h1;
    eng_done = 1;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; eng_done = 0;
    m_run = 1; m_done = 1; m[2] = 32'h1;
    chk(running_o, "R10 config wins RUN", 32'(running_o), 1);

    // R11 engine load, beats bus write
    @(negedge clk);
    eng_ld = 1; eng_desc = 32'hCAFE_0010; eng_addr = 32'h1000_0044;
    eng_xcnt = 16'h0033; eng_ycnt = 16'h0007;
    @(posedge clk); #1;
    eng_ld = 0;
    m[8] = 32'hCAFE_0010; m[9] = 32'h1000_0044; m[12] = 32'h33; m[14] = 32'h7;
    expect_rd(6'h20, 32'hCAFE_0010, "R11 cur desc");
    expect_rd(6'h24, 32'h1000_0044, "R11 cur addr");
    expect_rd(6'h30, 32'h33, "R11 cur x");
    op(1'b0, 2'b01, 6'h38, 0, "R11 cur y");

    // R5 stop
    op(1'b1, 2'b01, 6'h08, 32'h0000_0000, "R5 config stop");
    chk(stop_o && !running_o, "R5 stop_o pulse", {30'h0, stop_o, running_o}, 2);
    op(1'b1, 2'b01, 6'h0A, 32'h0000_0001, "R9 config upper half ignored");
    chk(!running_o && config_o == 0, "R5 no start from upper half", 32'(config_o), 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_size = 2'b10; bus_addr = 6'h30; bus_wdata = 32'h99;
    eng_ld = 1; eng_xcnt = 16'h0044;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0; eng_ld = 0;
    m[8] = eng_desc; m[9] = eng_addr; m[12] = 32'h44; m[14] = 32'h7;
    expect_rd(6'h30, 32'h44, "R11 load beats bus write");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [1:0] sz;
      logic [5:0] a;
      k = int'($urandom % 8);
      sz = (k < 3) ? 2'b01 : (k < 6) ? 2'b10 : (k == 6) ? 2'b00 : 2'b11;
      a = 6'($urandom);
      if ($urandom % 4 != 0) begin
        a[0] = 1'b0;
        if (sz == 2'b10) a[1] = 1'b0;
      end
      if ($urandom % 16 == 0)
        eng_pulse(1'($urandom), 1'($urandom));
      else
        op(1'($urandom), sz, a, $urandom, "R3 R4 R6 R7 R9 random");
      if (i % 50 == 0) begin
        chk(config_o == m[2][15:0] && pmap_o == m[11][15:0], "R12 outputs",
            {config_o, pmap_o}, {m[2][15:0], m[11][15:0]});
        chk(next_desc_o == m[0] && y_mod_o == m[7][15:0], "R12 pointer outputs", next_desc_o, m[0]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule